// File: doc/BRIEF.md
# Security Lifecycle Stage Decoder

This block settles, once per boot, which security stage a device is in. It reads a few one-time-programmable status words through a simple request/valid read port. It combines what it reads with a battery-domain validity flag, the pass/fail results of two configuration CRC checks and a boot-attempt counter. The result is a 32-bit stage code and a 32-bit mode code, together with a debug-disable level. The chosen values are held until the next decision.

The decision walks a fixed order. The production word is examined first. If it is blank, the battery flag is tested. The production word is then read again and the battery flag is tested again before the block falls back to the development stage. Two further blank checks can lower the development stage one step each. CRC failures then cap the stage. In production mode a boot-attempt limit causes a lockout. A battery failure, the attempt limit or an unknown stage raises a sticky halt request with a reason code.

Between decisions, a stage-advance command can move the stage up by exactly one step. The command is taken only when the status word that belongs to the target stage still reads blank. Programming that word is left to other logic.

Top module: `lc_stage_decoder`

## Requirements
- R1: After reset the stage code is 0xA535AC55 and the mode code is 0x648913E6 (development). Debug-disable is 1, and halt_req, done and mem_req are 0.
- R2: If the first read of the production status word (address ADDR_R5) is not 0xFFFFFFFF, the result is stage 0xA535AC59 with mode 0xAC371D01 and debug-disable 1. The battery flag is not consulted in this case.
- R3: If the production word reads 0xFFFFFFFF and batt_ok is 0 at the first battery check, the block raises halt_req with halt_code 0x5A00. No done pulse follows, and stage and mode keep their previous values.
- R4: On the development path the production word is read a second time, and a non-blank second read still gives the production result. A second battery check follows, and if batt_ok is 0 there the block halts with 0x5A00.
- R5: When both production reads are blank and both battery checks pass, the stage starts at 0xA535AC58 with mode 0x648913E6 and debug-disable 0. A blank word at ADDR_R4 lowers it to 0xA535AC57. After that, a blank word at ADDR_R3 lowers it to 0xA535AC56, whatever ADDR_R4 held.
- R6: If cfg_crc_ok is 0 the stage is capped at 0xA535AC57. If enc_crc_ok is 0 the stage is capped at 0xA535AC58. Neither cap raises a lower stage, and neither changes the mode or debug-disable.
- R7: When the mode is production and boot_count is at least BOOT_LIMIT (default 10), the block halts with halt_code 0x5A02 instead of completing. In development mode the count has no effect.
- R8: A command on adv_valid/adv_target is accepted when the current stage is exactly one below the target and the target's status word reads 0xFFFFFFFF. The status word is ADDR_WAFER for 0xA535AC56, ADDR_R3 for …57, ADDR_R4 for …58 and ADDR_R5 for …59. On acceptance, adv_ok pulses and stage_code becomes the target in the same cycle.
- R9: A command is rejected with an adv_err pulse and no stage change in three cases: the target is not one step above the current stage, the target word is not blank, or a decision is pending or running.
- R10: done is a single-cycle pulse that comes with the new stage, mode and debug-disable values. The stage code changes only with done or adv_ok. mem_req and mem_addr are held until mem_valid.
- R11: halt_req and halt_code stay set until reset. After a halt, further start pulses produce no decision and advance commands are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that requests a stage decision |
| batt_ok | input | 1 | Battery-domain validity flag |
| cfg_crc_ok | input | 1 | CRC result of the device configuration section |
| enc_crc_ok | input | 1 | CRC result of the encryption configuration section |
| boot_count | input | CNT_W | Boot-attempt counter |
| mem_req | output | 1 | Status-word read request, held until mem_valid |
| mem_addr | output | ADDR_W | Status-word address |
| mem_valid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data |
| adv_valid | input | 1 | Stage-advance command strobe |
| adv_target | input | 32 | Requested stage code |
| adv_ok | output | 1 | Advance accepted pulse |
| adv_err | output | 1 | Advance rejected pulse |
| stage_code | output | 32 | Current stage code |
| mode_code | output | 32 | Current mode code |
| dbg_disable | output | 1 | Debug access disabled |
| done | output | 1 | Decision complete pulse |
| halt_req | output | 1 | Sticky halt request |
| halt_code | output | 16 | Halt reason code |

## Verification
Every cycle, the assertions check four things. The halt is sticky and done is a lone pulse. The stage code moves only with done or an accepted advance, and an accepted advance moves it by exactly one. The outputs also stay consistent: a production mode always comes with debug disabled, a development mode only with stages 56 to 58, and a completed decision never hides a boot count past the limit. Only the bench scenarios can show the things that depend on what the status words and flags held. These include the exact stage chosen for each combination of blank words and CRC results, and the second production read overriding the first. They also include a battery flag that drops between the two checks, and advances that are rejected because a word was already programmed or a decision was in flight.

// File: rtl/lc_stage_pkg.sv
package lc_stage_pkg;

  localparam logic [31:0] STG_BARE  = 32'hA535AC55;
  localparam logic [31:0] STG_WAFER = 32'hA535AC56;
  localparam logic [31:0] STG_CHIP  = 32'hA535AC57;
  localparam logic [31:0] STG_DEV   = 32'hA535AC58;
  localparam logic [31:0] STG_PROD  = 32'hA535AC59;

  localparam logic [31:0] MODE_DEV  = 32'h648913E6;
  localparam logic [31:0] MODE_PROD = 32'hAC371D01;

  localparam logic [31:0] WORD_BLANK = 32'hFFFFFFFF;

  localparam logic [15:0] HALT_BATT  = 16'h5A00;
  localparam logic [15:0] HALT_LIMIT = 16'h5A02;
  localparam logic [15:0] HALT_STAGE = 16'h5AFF;

  typedef enum logic [4:0] {
    D_IDLE, D_R5A, D_W5A, D_E5A, D_BAT1,
    D_R5B, D_W5B, D_E5B, D_BAT2,
    D_R4, D_W4, D_E4, D_R3, D_W3, D_E3,
    D_CRC, D_LIM, D_HALT
  } dec_state_e;

  typedef enum logic {G_IDLE, G_WAIT} gate_state_e;

  function automatic logic stage_known(input logic [31:0] s);
    return (s >= STG_BARE) && (s <= STG_PROD);
  endfunction

  function automatic logic [31:0] stage_min(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/lc_otp_reader.sv
module lc_otp_reader #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      rd_data  <= '0;
      rd_done  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (!mem_req && go) begin
        mem_req  <= 1'b1;
        mem_addr <= go_addr;
      end else if (mem_req && mem_valid) begin
        mem_req <= 1'b0;
        rd_data <= mem_rdata;
        rd_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lc_boot_decoder.sv
module lc_boot_decoder
  import lc_stage_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 8,
  parameter int BOOT_LIMIT = 10,
  parameter int ADDR_R3    = 3,
  parameter int ADDR_R4    = 4,
  parameter int ADDR_R5    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              peer_busy,
  input  logic              batt_ok,
  input  logic              cfg_crc_ok,
  input  logic              enc_crc_ok,
  input  logic [CNT_W-1:0]  boot_count,
  input  logic [31:0]       rd_data,
  input  logic              rd_done,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              halted,
  output logic              commit,
  output logic [31:0]       c_stage,
  output logic [31:0]       c_mode,
  output logic              c_dbg,
  output logic              halt_set,
  output logic [15:0]       halt_code
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(BOOT_LIMIT);

  dec_state_e  state;
  logic        pend;
  logic [31:0] w_stage;
  logic [31:0] w_mode;
  logic        w_dbg;
  logic        blank;
  logic        limit_hit;
  logic        bad_stage;
  logic [31:0] crc_stage;

  assign blank     = (rd_data == WORD_BLANK);
  assign limit_hit = (w_mode != MODE_DEV) && (boot_count >= LIMIT_V);
  assign bad_stage = !stage_known(w_stage);

  always_comb begin
    crc_stage = w_stage;
    if (!cfg_crc_ok) crc_stage = stage_min(crc_stage, STG_CHIP);
    if (!enc_crc_ok) crc_stage = stage_min(crc_stage, STG_DEV);
  end

  always_comb begin
    rd_go   = 1'b0;
    rd_addr = ADDR_W'(ADDR_R5);
    unique case (state)
      D_R5A, D_R5B: rd_go = 1'b1;
      D_R4: begin rd_go = 1'b1; rd_addr = ADDR_W'(ADDR_R4); end
      D_R3: begin rd_go = 1'b1; rd_addr = ADDR_W'(ADDR_R3); end
      default: ;
    endcase
  end

  always_comb begin
    halt_set  = 1'b0;
    halt_code = HALT_BATT;
    if ((state == D_BAT1 || state == D_BAT2) && !batt_ok) begin
      halt_set = 1'b1;
    end else if (state == D_LIM && (limit_hit || bad_stage)) begin
      halt_set  = 1'b1;
      halt_code = limit_hit ? HALT_LIMIT : HALT_STAGE;
    end
  end

  assign commit  = (state == D_LIM) && !limit_hit && !bad_stage;
  assign busy    = pend || (state != D_IDLE && state != D_HALT);
  assign halted  = (state == D_HALT);
  assign c_stage = w_stage;
  assign c_mode  = w_mode;
  assign c_dbg   = w_dbg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= D_IDLE;
      pend    <= 1'b0;
      w_stage <= STG_BARE;
      w_mode  <= MODE_DEV;
      w_dbg   <= 1'b1;
    end else begin
      unique case (state)
        D_IDLE: if (pend && !peer_busy) begin
          pend  <= 1'b0;
          state <= D_R5A;
        end
        D_R5A: state <= D_W5A;
        D_W5A: if (rd_done) state <= D_E5A;
        D_E5A: begin
          if (!blank) begin
            w_stage <= STG_PROD;
            w_mode  <= MODE_PROD;
            w_dbg   <= 1'b1;
            state   <= D_CRC;
          end else begin
            state <= D_BAT1;
          end
        end
        D_BAT1: state <= batt_ok ? D_R5B : D_HALT;
        D_R5B: state <= D_W5B;
        D_W5B: if (rd_done) state <= D_E5B;
        D_E5B: begin
          if (!blank) begin
            w_stage <= STG_PROD;
            w_mode  <= MODE_PROD;
            w_dbg   <= 1'b1;
            state   <= D_CRC;
          end else begin
            state <= D_BAT2;
          end
        end
        D_BAT2: begin
          if (batt_ok) begin
            w_stage <= STG_DEV;
            w_mode  <= MODE_DEV;
            w_dbg   <= 1'b0;
            state   <= D_R4;
          end else begin
            state <= D_HALT;
          end
        end
        D_R4: state <= D_W4;
        D_W4: if (rd_done) state <= D_E4;
        D_E4: begin
          if (blank) w_stage <= STG_CHIP;
          state <= D_R3;
        end
        D_R3: state <= D_W3;
        D_W3: if (rd_done) state <= D_E3;
        D_E3: begin
          if (blank) w_stage <= STG_WAFER;
          state <= D_CRC;
        end
        D_CRC: begin
          w_stage <= crc_stage;
          state   <= D_LIM;
        end
        D_LIM: state <= (limit_hit || bad_stage) ? D_HALT : D_IDLE;
        D_HALT: state <= D_HALT;
        default: state <= D_HALT;
      endcase
      if (start && state != D_HALT) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/lc_advance_gate.sv
module lc_advance_gate
  import lc_stage_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int ADDR_WAFER = 2,
  parameter int ADDR_R3    = 3,
  parameter int ADDR_R4    = 4,
  parameter int ADDR_R5    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_target,
  input  logic [31:0]       cur_stage,
  input  logic              blocked,
  input  logic [31:0]       rd_data,
  input  logic              rd_done,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              acc_now,
  output logic              rej_now,
  output logic [31:0]       new_stage
);

  gate_state_e st;
  logic [31:0] tgt;
  logic        legal;

  assign legal = stage_known(cmd_target) && (cmd_target != STG_BARE) &&
                 (cur_stage == cmd_target - 32'd1);

  always_comb begin
    unique case (cmd_target)
      STG_WAFER: rd_addr = ADDR_W'(ADDR_WAFER);
      STG_CHIP:  rd_addr = ADDR_W'(ADDR_R3);
      STG_DEV:   rd_addr = ADDR_W'(ADDR_R4);
      default:   rd_addr = ADDR_W'(ADDR_R5);
    endcase
  end

  assign rd_go     = (st == G_IDLE) && cmd_valid && !blocked && legal;
  assign busy      = (st != G_IDLE);
  assign new_stage = tgt;
  assign acc_now   = (st == G_WAIT) && rd_done && (rd_data == WORD_BLANK);
  assign rej_now   = ((st == G_IDLE) && cmd_valid && !rd_go) ||
                     ((st == G_WAIT) && cmd_valid) ||
                     ((st == G_WAIT) && rd_done && (rd_data != WORD_BLANK));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= G_IDLE;
      tgt <= STG_BARE;
    end else begin
      unique case (st)
        G_IDLE: if (rd_go) begin
          tgt <= cmd_target;
          st  <= G_WAIT;
        end
        G_WAIT: if (rd_done) st <= G_IDLE;
        default: st <= G_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lc_stage_decoder.sv
module lc_stage_decoder
  import lc_stage_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 8,
  parameter int BOOT_LIMIT = 10,
  parameter int ADDR_WAFER = 2,
  parameter int ADDR_R3    = 3,
  parameter int ADDR_R4    = 4,
  parameter int ADDR_R5    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              batt_ok,
  input  logic              cfg_crc_ok,
  input  logic              enc_crc_ok,
  input  logic [CNT_W-1:0]  boot_count,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata,
  input  logic              adv_valid,
  input  logic [31:0]       adv_target,
  output logic              adv_ok,
  output logic              adv_err,
  output logic [31:0]       stage_code,
  output logic [31:0]       mode_code,
  output logic              dbg_disable,
  output logic              done,
  output logic              halt_req,
  output logic [15:0]       halt_code
);

  logic              dec_go, gate_go, rd_done;
  logic [ADDR_W-1:0] dec_addr, gate_addr;
  logic [31:0]       rd_data;
  logic              dec_busy, dec_halted, gate_busy;
  logic              commit, c_dbg, halt_set;
  logic [31:0]       c_stage, c_mode, new_stage;
  logic [15:0]       halt_code_n;
  logic              acc_now, rej_now;

  lc_otp_reader #(.ADDR_W(ADDR_W), .DATA_W(32)) reader_i (
    .clk(clk), .rst(rst),
    .go(dec_go | gate_go),
    .go_addr(dec_go ? dec_addr : gate_addr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .rd_done(rd_done)
  );

  lc_boot_decoder #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BOOT_LIMIT(BOOT_LIMIT),
    .ADDR_R3(ADDR_R3), .ADDR_R4(ADDR_R4), .ADDR_R5(ADDR_R5)
  ) decoder_i (
    .clk(clk), .rst(rst), .start(start), .peer_busy(gate_busy),
    .batt_ok(batt_ok), .cfg_crc_ok(cfg_crc_ok), .enc_crc_ok(enc_crc_ok),
    .boot_count(boot_count), .rd_data(rd_data), .rd_done(rd_done),
    .rd_go(dec_go), .rd_addr(dec_addr), .busy(dec_busy), .halted(dec_halted),
    .commit(commit), .c_stage(c_stage), .c_mode(c_mode), .c_dbg(c_dbg),
    .halt_set(halt_set), .halt_code(halt_code_n)
  );

  lc_advance_gate #(
    .ADDR_W(ADDR_W), .ADDR_WAFER(ADDR_WAFER),
    .ADDR_R3(ADDR_R3), .ADDR_R4(ADDR_R4), .ADDR_R5(ADDR_R5)
  ) gate_i (
    .clk(clk), .rst(rst), .cmd_valid(adv_valid), .cmd_target(adv_target),
    .cur_stage(stage_code), .blocked(dec_busy | dec_halted),
    .rd_data(rd_data), .rd_done(rd_done),
    .rd_go(gate_go), .rd_addr(gate_addr), .busy(gate_busy),
    .acc_now(acc_now), .rej_now(rej_now), .new_stage(new_stage)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_code  <= STG_BARE;
      mode_code   <= MODE_DEV;
      dbg_disable <= 1'b1;
      done        <= 1'b0;
      halt_req    <= 1'b0;
      halt_code   <= '0;
      adv_ok      <= 1'b0;
      adv_err     <= 1'b0;
    end else begin
      done    <= commit;
      adv_ok  <= acc_now;
      adv_err <= rej_now;
      if (commit) begin
        stage_code  <= c_stage;
        mode_code   <= c_mode;
        dbg_disable <= c_dbg;
      end else if (acc_now) begin
        stage_code <= new_stage;
      end
      if (halt_set && !halt_req) begin
        halt_req  <= 1'b1;
        halt_code <= halt_code_n;
      end
    end
  end

endmodule

// File: rtl/lc_stage_decoder_chk.sv
module lc_stage_decoder_chk
  import lc_stage_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 8,
  parameter int BOOT_LIMIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  boot_count,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              adv_ok,
  input logic [31:0]       stage_code,
  input logic [31:0]       mode_code,
  input logic              dbg_disable,
  input logic              done,
  input logic              halt_req,
  input logic [15:0]       halt_code
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(BOOT_LIMIT);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> halt_req && $stable(halt_code));

  p_halt_reason_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req) |-> (halt_code == HALT_BATT || halt_code == HALT_LIMIT ||
                         halt_code == HALT_STAGE));

  p_stage_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!done && !adv_ok) |-> $stable(stage_code));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_prod_dbg_r2: assert property (@(posedge clk) disable iff (rst)
    (done && mode_code == MODE_PROD) |-> dbg_disable);

  p_dev_range_r5: assert property (@(posedge clk) disable iff (rst)
    (done && mode_code == MODE_DEV) |->
      (!dbg_disable && stage_code >= STG_WAFER && stage_code <= STG_DEV));

  p_adv_step_r8: assert property (@(posedge clk) disable iff (rst)
    adv_ok |-> (stage_code == $past(stage_code) + 32'd1));

  p_adv_not_done_r9: assert property (@(posedge clk) disable iff (rst)
    !(adv_ok && done));

  p_limit_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !(mode_code == MODE_PROD && $past(boot_count) >= LIMIT_V));

endmodule

bind lc_stage_decoder lc_stage_decoder_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BOOT_LIMIT(BOOT_LIMIT)
) chk_i (
  .clk(clk), .rst(rst), .boot_count(boot_count),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
  .adv_ok(adv_ok), .stage_code(stage_code), .mode_code(mode_code),
  .dbg_disable(dbg_disable), .done(done), .halt_req(halt_req),
  .halt_code(halt_code)
);

// File: tb/lc_stage_decoder_tb_top.sv
module lc_stage_decoder_tb_top;

  localparam logic [31:0] B   = 32'hFFFFFFFF;
  localparam logic [31:0] P   = 32'h00C0FFEE;
  localparam logic [31:0] S55 = 32'hA535AC55;
  localparam logic [31:0] S56 = 32'hA535AC56;
  localparam logic [31:0] S57 = 32'hA535AC57;
  localparam logic [31:0] S58 = 32'hA535AC58;
  localparam logic [31:0] S59 = 32'hA535AC59;
  localparam logic [31:0] MD  = 32'h648913E6;
  localparam logic [31:0] MP  = 32'hAC371D01;

  typedef struct packed {
    logic [31:0] w5, w4, w3;
    logic        bat, cfg, enc;
    logic [7:0]  cnt;
    logic        ehalt;
    logic [15:0] hcode;
    logic [31:0] est, emode;
    logic        edbg;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{P, B, B, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S59, MP, 1'b1}, // R2
    '{B, P, P, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S58, MD, 1'b0}, // R5
    '{B, B, P, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S57, MD, 1'b0}, // R5
    '{B, B, B, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S56, MD, 1'b0}, // R5
    '{B, P, B, 1'b1, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S56, MD, 1'b0}, // R5
    '{B, P, P, 1'b0, 1'b1, 1'b1, 8'd0,   1'b1, 16'h5A00, S55, MD, 1'b1}, // R3
    '{B, P, P, 1'b1, 1'b0, 1'b1, 8'd0,   1'b0, 16'h0,    S57, MD, 1'b0}, // R6
    '{B, P, P, 1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 16'h0,    S58, MD, 1'b0}, // R6
    '{P, B, B, 1'b1, 1'b0, 1'b1, 8'd0,   1'b0, 16'h0,    S57, MP, 1'b1}, // R6
    '{P, B, B, 1'b1, 1'b1, 1'b0, 8'd0,   1'b0, 16'h0,    S58, MP, 1'b1}, // R6
    '{B, B, B, 1'b1, 1'b0, 1'b0, 8'd0,   1'b0, 16'h0,    S56, MD, 1'b0}, // R6
    '{P, B, B, 1'b1, 1'b1, 1'b1, 8'd10,  1'b1, 16'h5A02, S55, MD, 1'b1}, // R7
    '{P, B, B, 1'b1, 1'b1, 1'b1, 8'd9,   1'b0, 16'h0,    S59, MP, 1'b1}, // R7
    '{B, P, P, 1'b1, 1'b1, 1'b1, 8'd200, 1'b0, 16'h0,    S58, MD, 1'b0}, // R7
    '{P, B, B, 1'b1, 1'b0, 1'b1, 8'd11,  1'b1, 16'h5A02, S55, MD, 1'b1}, // R7
    '{P, B, B, 1'b0, 1'b1, 1'b1, 8'd0,   1'b0, 16'h0,    S59, MP, 1'b1}  // R2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic batt_set = 1'b1;
  logic batt_drop;
  logic batt_ok;
  logic cfg_crc_ok = 1'b1;
  logic enc_crc_ok = 1'b1;
  logic [7:0] boot_count = '0;
  logic mem_req;
  logic [3:0] mem_addr;
  logic mem_valid;
  logic [31:0] mem_rdata;
  logic adv_valid = 1'b0;
  logic [31:0] adv_target = '0;
  logic adv_ok, adv_err;
  logic [31:0] stage_code, mode_code;
  logic dbg_disable, done, halt_req;
  logic [15:0] halt_code;

  logic [31:0] mem_w [16];
  logic        alt5_en = 1'b0;
  logic [31:0] alt5_val = '0;
  logic        drop_en = 1'b0;
  int          reads5;
  int          lat;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  assign batt_ok = batt_set & ~batt_drop;

  always #5 clk = ~clk;

  lc_stage_decoder dut_i (
    .clk(clk), .rst(rst), .start(start), .batt_ok(batt_ok),
    .cfg_crc_ok(cfg_crc_ok), .enc_crc_ok(enc_crc_ok), .boot_count(boot_count),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .adv_valid(adv_valid), .adv_target(adv_target),
    .adv_ok(adv_ok), .adv_err(adv_err), .stage_code(stage_code),
    .mode_code(mode_code), .dbg_disable(dbg_disable), .done(done),
    .halt_req(halt_req), .halt_code(halt_code)
  );

  // Status-word memory model: two-cycle latency, one-cycle valid pulse.
  initial begin
    mem_valid = 1'b0;
    mem_rdata = '0;
    batt_drop = 1'b0;
    reads5 = 0;
    lat = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_valid = 1'b0; batt_drop = 1'b0; reads5 = 0; lat = 0;
      end else if (mem_valid) begin
        mem_valid = 1'b0;
      end else if (mem_req) begin
        lat++;
        if (lat >= 2) begin
          lat = 0;
          mem_valid = 1'b1;
          if (mem_addr == 4'd5 && reads5 == 1 && alt5_en) mem_rdata = alt5_val;
          else mem_rdata = mem_w[mem_addr];
          if (mem_addr == 4'd5) begin
            reads5++;
            if (reads5 == 2 && drop_en) batt_drop = 1'b1;
          end
        end
      end else begin
        lat = 0;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit saw_done, output bit saw_halt);
    saw_done = 1'b0; saw_halt = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin saw_done = 1'b1; break; end
      if (halt_req) begin saw_halt = 1'b1; break; end
    end
  endtask

  task automatic adv(input logic [31:0] target, output bit ok, output bit got);
    adv_valid = 1'b1;
    adv_target = target;
    ok = 1'b0; got = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (adv_ok) begin ok = 1'b1; got = 1'b1; end
      else if (adv_err) begin ok = 1'b0; got = 1'b1; end
      adv_valid = 1'b0;
    end
  endtask

  task automatic setup(input logic [31:0] w5, input logic [31:0] w4, input logic [31:0] w3,
                       input logic bat, input logic cfg, input logic enc, input logic [7:0] cnt);
    for (int a = 0; a < 16; a++) mem_w[a] = P;
    mem_w[2] = B;
    mem_w[5] = w5; mem_w[4] = w4; mem_w[3] = w3;
    batt_set = bat; cfg_crc_ok = cfg; enc_crc_ok = enc; boot_count = cnt;
    alt5_en = 1'b0; drop_en = 1'b0;
    do_reset();
  endtask

  initial begin
    bit sd, sh, ok, got;
    setup(P, B, B, 1'b1, 1'b1, 1'b1, 8'd0);

    // R1: reset state
    chk("R1", "stage", stage_code, S55);
    chk("R1", "mode", mode_code, MD);
    chk("R1", "dbg", 32'(dbg_disable), 32'd1);
    chk("R1", "halt", 32'(halt_req), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].w5, VECS[v].w4, VECS[v].w3, VECS[v].bat,
            VECS[v].cfg, VECS[v].enc, VECS[v].cnt);
      pulse_start();
      wait_end(sd, sh);
      chk("R2-table", $sformatf("vec%0d halt", v), 32'(sh), 32'(VECS[v].ehalt));
      chk("R5-table", $sformatf("vec%0d stage", v), stage_code, VECS[v].est);
      chk("R6-table", $sformatf("vec%0d mode", v), mode_code, VECS[v].emode);
      chk("R7-table", $sformatf("vec%0d dbg", v), 32'(dbg_disable), 32'(VECS[v].edbg));
      if (VECS[v].ehalt)
        chk("R3-table", $sformatf("vec%0d code", v), 32'(halt_code), 32'(VECS[v].hcode));
    end

    // R4: second production read overrides a blank first read
    setup(B, P, P, 1'b1, 1'b1, 1'b1, 8'd0);
    alt5_en = 1'b1; alt5_val = P;
    pulse_start();
    wait_end(sd, sh);
    chk("R4", "second read done", 32'(sd), 32'd1);
    chk("R4", "second read stage", stage_code, S59);
    chk("R4", "second read mode", mode_code, MP);
    chk("R4", "prod word read count", reads5, 2);

    // R4: development path reads production word twice
    setup(B, P, P, 1'b1, 1'b1, 1'b1, 8'd0);
    pulse_start();
    wait_end(sd, sh);
    chk("R4", "dev read count", reads5, 2);

    // R4: battery drops before second check
    setup(B, P, P, 1'b1, 1'b1, 1'b1, 8'd0);
    drop_en = 1'b1;
    pulse_start();
    wait_end(sd, sh);
    chk("R4", "battery drop halt", 32'(sh), 32'd1);
    chk("R4", "battery drop code", 32'(halt_code), 32'h5A00);
    chk("R4", "battery drop stage", stage_code, S55);

    // R10: done is one cycle, outputs hold afterwards
    setup(B, B, P, 1'b1, 1'b1, 1'b1, 8'd0);
    pulse_start();
    wait_end(sd, sh);
    @(negedge clk);
    chk("R10", "done width", 32'(done), 32'd0);
    repeat (5) @(negedge clk);
    chk("R10", "stage held", stage_code, S57);
    chk("R10", "mode held", mode_code, MD);

    // R8: advance from reset stage, then decode, then step up
    setup(B, B, B, 1'b1, 1'b1, 1'b1, 8'd0);
    adv(S56, ok, got);
    chk("R8", "adv56 ok", 32'(ok & got), 32'd1);
    chk("R8", "adv56 stage", stage_code, S56);
    pulse_start();
    wait_end(sd, sh);
    chk("R8", "decode stage", stage_code, S56);
    adv(S57, ok, got);
    chk("R8", "adv57 ok", 32'(ok & got), 32'd1);
    chk("R8", "adv57 stage", stage_code, S57);
    adv(S58, ok, got);
    chk("R8", "adv58 ok", 32'(ok & got), 32'd1);
    adv(S59, ok, got);
    chk("R8", "adv59 ok", 32'(ok & got), 32'd1);
    chk("R8", "adv59 stage", stage_code, S59);

    // R9: illegal steps rejected
    adv(S59, ok, got);
    chk("R9", "repeat target rejected", 32'(got & ~ok), 32'd1);
    adv(S57, ok, got);
    chk("R9", "backward target rejected", 32'(got & ~ok), 32'd1);
    chk("R9", "stage after reject", stage_code, S59);

    // R9: target word already programmed
    setup(B, B, B, 1'b1, 1'b1, 1'b1, 8'd0);
    pulse_start();
    wait_end(sd, sh);
    mem_w[3] = P;
    adv(S57, ok, got);
    chk("R9", "written word rejected", 32'(got & ~ok), 32'd1);
    chk("R9", "stage unchanged", stage_code, S56);

    // R9: advance while a decision is pending
    setup(B, P, P, 1'b1, 1'b1, 1'b1, 8'd0);
    pulse_start();
    adv(S56, ok, got);
    chk("R9", "busy reject", 32'(got & ~ok), 32'd1);
    wait_end(sd, sh);
    chk("R9", "decision after busy reject", stage_code, S58);

    // R11: halt is sticky, restart and advance ignored
    setup(B, P, P, 1'b0, 1'b1, 1'b1, 8'd0);
    pulse_start();
    wait_end(sd, sh);
    chk("R11", "halted", 32'(sh), 32'd1);
    batt_set = 1'b1;
    pulse_start();
    sd = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done) sd = 1'b1;
    end
    chk("R11", "no done after halt", 32'(sd), 32'd0);
    chk("R11", "halt held", 32'(halt_req), 32'd1);
    chk("R11", "code held", 32'(halt_code), 32'h5A00);
    adv(S56, ok, got);
    chk("R11", "advance rejected", 32'(got & ~ok), 32'd1);
    chk("R11", "stage after halt", stage_code, S55);

    summary();
  end

endmodule